// File: doc/BRIEF.md
# FM Port Write Trap

This block sits on a simple CPU I/O bus and watches for writes aimed at a fixed four-byte window where a legacy FM synthesizer used to live. It stores each access in three small trap registers. A write to an index port records which bank was addressed and the index byte. A write to a data port records the data byte. When a data port is written and trapping is enabled, the block raises a level interrupt toward the CPU, either NMI or SMI as configured. System software can then read the trap registers and emulate the missing synthesizer.

The trap registers are read back through a second, relocatable four-byte status window. A status read returns the register selected by the two low address bits. When trapping is enabled, the same read also acknowledges the interrupt. The status window responds only when its programmed base is nonzero and I/O space decoding is enabled. The FM window itself is decoded at all times.

Top module: `fmtrap_top`

## Requirements
- R1: After reset the bank ID, captured index and captured data registers all read 0x00, and NMI and SMI are low.
- R2: A write inside the FM window with address bit 0 clear is an index write. It stores the written byte as the captured index and sets the bank ID to 0x02 when address bit 1 is set, or to 0x01 when it is clear. The captured data is not changed.
- R3: A write inside the FM window with address bit 0 set is a data write. It stores the byte as the captured data and leaves the bank ID and the captured index unchanged.
- R4: A data write with the trap enabled asserts the selected interrupt line at the first clock edge after the write cycle. An index write never asserts either line.
- R5: With the trap disabled, a data write still captures its byte but asserts neither line.
- R6: When the select input is high the line raised is SMI; when it is low the line raised is NMI. The other line stays unchanged.
- R7: During a status window read, io_rdata gives the bank ID at offset 0, the captured index at offset 1, the captured data at offset 2 and 0x00 at offset 3, in the same cycle as the read. io_rdata is 0x00 whenever no status read is decoded.
- R8: A status read with the trap enabled clears the selected line at the next clock edge. A status read with the trap disabled leaves both lines unchanged.
- R9: The status window base is the programmed base with its two low bits treated as zero. The window decodes only when that masked base is nonzero and the I/O space enable is high; otherwise a read there returns 0x00 and clears nothing.
- R10: An asserted line holds until a clearing status read or reset. A further data write keeps it high. If a raising data write and a clearing read fall in the same cycle, the line ends up high.
- R11: Writes outside the FM window, including writes into the status window, change no trap register and raise no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | ADDR_W (16) | I/O address of the current cycle |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Status window read data, combinational |
| trap_en | input | 1 | Enables interrupt raising and read acknowledge |
| smi_sel | input | 1 | High selects SMI, low selects NMI |
| io_space_en | input | 1 | I/O space enable for the status window |
| stat_base | input | ADDR_W (16) | Programmed status window base; low two bits ignored |
| nmi | output | 1 | Level NMI request |
| smi | output | 1 | Level SMI request |

## Verification
Read data is due in the same cycle as the read strobe. It is sampled one time unit after the inputs are driven on the falling edge, before the next rising edge. Register captures and line changes come from a single register stage, so they are due at the rising edge that ends the access cycle. The bench compares them at the following falling edge, against a behavioural model that it also advances at that rising edge. Status reads made after each access expose the captured registers at the ports. These reads also show whether an access that should have been ignored left anything changed.

// File: rtl/fmtrap_pkg.sv
package fmtrap_pkg;

  // Status window register offsets; the order is fixed by the read decode.
  typedef enum logic [1:0] {
    OFS_BANK  = 2'd0,
    OFS_INDEX = 2'd1,
    OFS_DATA  = 2'd2,
    OFS_RSVD  = 2'd3
  } stat_ofs_e;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] BANK_ID_LO = 8'h01;
  localparam logic [BYTE_W-1:0] BANK_ID_HI = 8'h02;

  typedef struct packed {
    logic [BYTE_W-1:0] bank;
    logic [BYTE_W-1:0] index;
    logic [BYTE_W-1:0] data;
  } trap_regs_t;

endpackage

// File: rtl/fmtrap_rst_sync.sv
module fmtrap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fmtrap_decode.sv
module fmtrap_decode
  import fmtrap_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] FM_BASE = 16'h0388
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [ADDR_W-1:0] stat_base,
  input  logic              io_space_en,
  output logic              fm_hit,
  output logic              st_hit,
  output stat_ofs_e         ofs
);

  localparam logic [ADDR_W-1:0] WIN_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

  logic [ADDR_W-1:0] base_masked;
  logic              base_valid;

  always_comb begin
    base_masked = stat_base & WIN_MASK;
    base_valid  = (base_masked != '0) && io_space_en;
    fm_hit      = (io_addr[ADDR_W-1:2] == FM_BASE[ADDR_W-1:2]);
    st_hit      = base_valid && (io_addr[ADDR_W-1:2] == base_masked[ADDR_W-1:2]);
    ofs         = stat_ofs_e'(io_addr[1:0]);
  end

endmodule

// File: rtl/fmtrap_capture.sv
module fmtrap_capture
  import fmtrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_idx,
  input  logic              wr_dat,
  input  logic              bank_hi,
  input  logic [BYTE_W-1:0] wdata,
  output trap_regs_t        regs
);

  trap_regs_t regs_q;
  trap_regs_t regs_d;
  logic       regs_en;

  always_comb begin
    regs_d  = regs_q;
    regs_en = wr_idx | wr_dat;
    if (wr_idx) begin
      regs_d.bank  = bank_hi ? BANK_ID_HI : BANK_ID_LO;
      regs_d.index = wdata;
    end else if (wr_dat) begin
      regs_d.data  = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       regs_q <= '0;
    else if (regs_en) regs_q <= regs_d;
  end

  assign regs = regs_q;

endmodule

// File: rtl/fmtrap_irq.sv
module fmtrap_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic smi_sel,
  output logic nmi,
  output logic smi
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_q;
  logic [N_LINES-1:0] line_d;
  logic [N_LINES-1:0] line_en;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    localparam logic SEL_VAL = (g == 1);
    logic set_g;
    logic clr_g;

    always_comb begin
      set_g      = raise & (smi_sel == SEL_VAL);
      clr_g      = clear & (smi_sel == SEL_VAL);
      line_en[g] = set_g | clr_g;
      line_d[g]  = set_g | (line_q[g] & ~clr_g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          line_q[g] <= 1'b0;
      else if (line_en[g]) line_q[g] <= line_d[g];
    end
  end

  assign nmi = line_q[0];
  assign smi = line_q[1];

endmodule

// File: rtl/fmtrap_top.sv
module fmtrap_top
  import fmtrap_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] FM_BASE = 16'h0388
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              trap_en,
  input  logic              smi_sel,
  input  logic              io_space_en,
  input  logic [ADDR_W-1:0] stat_base,
  output logic              nmi,
  output logic              smi
);

  logic       rst_n_sync;
  logic       fm_hit;
  logic       st_hit;
  stat_ofs_e  ofs;
  logic       wr_idx;
  logic       wr_dat;
  logic       rd_stat;
  logic       raise;
  logic       clear;
  trap_regs_t regs;
  logic [7:0] cap_bank;
  logic [7:0] cap_index;
  logic [7:0] cap_data;

  fmtrap_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fmtrap_decode #(.ADDR_W(ADDR_W), .FM_BASE(FM_BASE)) u_dec (
    .io_addr     (io_addr),
    .stat_base   (stat_base),
    .io_space_en (io_space_en),
    .fm_hit      (fm_hit),
    .st_hit      (st_hit),
    .ofs         (ofs)
  );

  always_comb begin
    wr_idx  = io_wr & fm_hit & ~io_addr[0];
    wr_dat  = io_wr & fm_hit &  io_addr[0];
    rd_stat = io_rd & st_hit;
    raise   = wr_dat  & trap_en;
    clear   = rd_stat & trap_en;
  end

  fmtrap_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_idx  (wr_idx),
    .wr_dat  (wr_dat),
    .bank_hi (io_addr[1]),
    .wdata   (io_wdata),
    .regs    (regs)
  );

  fmtrap_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .raise   (raise),
    .clear   (clear),
    .smi_sel (smi_sel),
    .nmi     (nmi),
    .smi     (smi)
  );

  assign cap_bank  = regs.bank;
  assign cap_index = regs.index;
  assign cap_data  = regs.data;

  always_comb begin
    io_rdata = '0;
    if (rd_stat) begin
      unique case (ofs)
        OFS_BANK:  io_rdata = cap_bank;
        OFS_INDEX: io_rdata = cap_index;
        OFS_DATA:  io_rdata = cap_data;
        OFS_RSVD:  io_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/fmtrap_chk.sv
module fmtrap_chk #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] FM_BASE = 16'h0388
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic              trap_en,
  input logic              smi_sel,
  input logic              nmi,
  input logic              smi,
  input logic [7:0]        cap_bank,
  input logic [7:0]        cap_index
);

  logic in_fm;
  assign in_fm = (io_addr[ADDR_W-1:2] == FM_BASE[ADDR_W-1:2]);

  // R4: index writes never raise a line
  a_r4_index_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && in_fm && !io_addr[0] && !nmi && !smi) |=> (!nmi && !smi));

  // R4, R6: enabled data write raises NMI when select is low
  a_r4_data_raises_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && in_fm && io_addr[0] && trap_en && !smi_sel) |=> nmi);

  // R6: enabled data write raises SMI when select is high
  a_r6_data_raises_smi: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && in_fm && io_addr[0] && trap_en && smi_sel) |=> smi);

  // R3: data writes leave bank and index alone
  a_r3_bank_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && in_fm && io_addr[0]) |=> ($stable(cap_bank) && $stable(cap_index)));

  // R10: NMI holds unless an enabled read with NMI selected happens
  a_r10_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && !(io_rd && trap_en && !smi_sel)) |=> nmi);

  // R10: SMI holds unless an enabled read with SMI selected happens
  a_r10_smi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (smi && !(io_rd && trap_en && smi_sel)) |=> smi);

  // R8: lines never rise without an enabled data write
  a_r8_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && in_fm && io_addr[0] && trap_en) |=> (!$rose(nmi) && !$rose(smi)));

  // R7: read data is idle without a read strobe
  a_r7_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));

endmodule

bind fmtrap_top fmtrap_chk #(.ADDR_W(ADDR_W), .FM_BASE(FM_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .io_addr   (io_addr),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_rdata  (io_rdata),
  .trap_en   (trap_en),
  .smi_sel   (smi_sel),
  .nmi       (nmi),
  .smi       (smi),
  .cap_bank  (cap_bank),
  .cap_index (cap_index)
);

// File: tb/test_fmtrap_top.sv
`timescale 1ns/1ps
module test_fmtrap_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_rdata;
  logic        trap_en;
  logic        smi_sel;
  logic        io_space_en;
  logic [15:0] stat_base;
  logic        nmi;
  logic        smi;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int m_bank, m_index, m_data;
  bit m_nmi, m_smi;

  fmtrap_top i_fmtrap_top (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .trap_en(trap_en),
    .smi_sel(smi_sel), .io_space_en(io_space_en), .stat_base(stat_base),
    .nmi(nmi), .smi(smi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit fm_win(input int a);
    return (a >= 'h388) && (a <= 'h38B);
  endfunction

  function automatic bit st_win(input int a);
    int b;
    b = stat_base - (stat_base % 4);
    return io_space_en && (b != 0) && (a >= b) && (a < b + 4);
  endfunction

  function automatic int exp_rdata();
    if (!(io_rd && st_win(io_addr))) return 0;
    case (io_addr % 4)
      0: return m_bank;
      1: return m_index;
      2: return m_data;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit set_l, clr_l;
    set_l = 0; clr_l = 0;
    if (io_wr && fm_win(io_addr)) begin
      if (io_addr % 2 == 0) begin
        m_bank  = ((io_addr / 2) % 2 == 1) ? 2 : 1;
        m_index = io_wdata;
      end else begin
        m_data = io_wdata;
        set_l  = trap_en;
      end
    end
    if (io_rd && st_win(io_addr) && trap_en) clr_l = 1;
    if (smi_sel) m_smi = set_l || (m_smi && !clr_l);
    else         m_nmi = set_l || (m_nmi && !clr_l);
  endtask

  // One bus cycle; called at a falling edge, returns at the next one.
  task automatic cyc(input string tag, input bit wr, input bit rd,
                     input logic [15:0] a, input logic [7:0] d);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
    #1;
    check(tag, "rdata", io_rdata, exp_rdata());
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "nmi", nmi, m_nmi);
    check(tag, "smi", smi, m_smi);
    io_wr = 0; io_rd = 0;
  endtask

  task automatic rd(input string tag, input logic [15:0] a);
    cyc(tag, 0, 1, a, 8'h00);
  endtask

  task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
    cyc(tag, 1, 0, a, d);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_bank = 0; m_index = 0; m_data = 0; m_nmi = 0; m_smi = 0;
    rst_n = 0; io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
    trap_en = 1; smi_sel = 0; io_space_en = 1; stat_base = 16'h0E00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state through the status window
    check("R1", "nmi", nmi, 0);
    check("R1", "smi", smi, 0);
    for (int o = 0; o < 4; o++) rd("R1", 16'h0E00 + 16'(o));

    // R2: index writes to both banks
    wr("R2", 16'h0388, 8'h20);
    rd("R2", 16'h0E00); rd("R2", 16'h0E01);
    check("R2", "bank", m_bank, 1);
    wr("R2", 16'h038A, 8'h45);
    rd("R2", 16'h0E00); rd("R2", 16'h0E01); rd("R2", 16'h0E02);

    // R3 R4: data write captures and raises NMI
    wr("R4", 16'h0389, 8'h7E);
    check("R4", "nmi raised", nmi, 1);
    rd("R3", 16'h0E02);
    // reads above with trap enabled cleared nmi (R8); raise again for R3 bank check
    wr("R3", 16'h0389, 8'h11);
    rd("R3", 16'h0E00);
    check("R8", "nmi cleared by read", nmi, 0);

    // R7: offset 3 reads zero
    rd("R7", 16'h0E03);

    // R6: SMI selection
    smi_sel = 1;
    wr("R6", 16'h038B, 8'h33);
    check("R6", "smi raised", smi, 1);
    check("R6", "nmi idle", nmi, 0);
    rd("R6", 16'h0E02);
    check("R8", "smi cleared", smi, 0);
    smi_sel = 0;

    // R5: disabled trap captures without raising
    trap_en = 0;
    wr("R5", 16'h0389, 8'hA5);
    check("R5", "nmi quiet", nmi, 0);
    rd("R5", 16'h0E02);

    // R8: read with trap disabled keeps the line
    trap_en = 1;
    wr("R8", 16'h0389, 8'h01);
    trap_en = 0;
    rd("R8", 16'h0E00);
    check("R8", "nmi kept", nmi, 1);
    trap_en = 1;

    // R10: hold, repeated write, set beats clear
    cyc("R10", 0, 0, 16'h0000, 8'h00);
    cyc("R10", 0, 0, 16'h0000, 8'h00);
    wr("R10", 16'h0389, 8'h02);
    check("R10", "nmi held", nmi, 1);
    rd("R10", 16'h0E01);
    wr("R10", 16'h0389, 8'h03);
    cyc("R10", 1, 1, 16'h0389, 8'h04);
    stat_base = 16'h0388;
    cyc("R10", 1, 1, 16'h0389, 8'h05);
    check("R10", "set wins", nmi, 1);
    stat_base = 16'h0E00;
    rd("R10", 16'h0E00);

    // R9: base low bits ignored, enable and zero base gating
    wr("R9", 16'h0389, 8'h66);
    stat_base = 16'h0E03;
    rd("R9", 16'h0E02);
    wr("R9", 16'h0389, 8'h67);
    io_space_en = 0;
    rd("R9", 16'h0E02);
    check("R9", "no clear when disabled", nmi, 1);
    io_space_en = 1;
    stat_base = 16'h0003;
    rd("R9", 16'h0000);
    rd("R9", 16'h0003);
    stat_base = 16'h0E00;
    rd("R9", 16'h0E02);

    // R11: writes outside the window
    wr("R11", 16'h038C, 8'hDE);
    wr("R11", 16'h0384, 8'hAD);
    wr("R11", 16'h0E01, 8'hBE);
    wr("R11", 16'h0E02, 8'hEF);
    check("R11", "no raise", nmi, 0);
    for (int o = 0; o < 3; o++) rd("R11", 16'h0E00 + 16'(o));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule